// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block collects interrupt sources of several kinds. It presents one request to a processor core: the highest-priority source that is both pending and enabled, with its index and a vector address. Three sources are fixed at the top of the priority order: a non-maskable event, an illegal-opcode event and a software trap. No enable of any kind can block them.

Below them come the external pins, then the internal maskable sources, then a group of multiplexed sources. Each of these has a bit in a mask register. All of them also depend on a global enable that the core turns on and off with single-cycle commands. The multiplexed group is further gated by a single group enable.

Each external pin can trigger in one of four styles: high level, low level, rising edge or falling edge. An edge is held as pending until the core acknowledges it. A level request lasts only while the pin stays at its active level. The vector is formed from a programmable base address plus four bytes per source index.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Sources 0 (non-maskable), 1 (illegal opcode) and 2 (trap) are latched when their input is high at a clock edge. They are presented whatever the mask, global enable and group enable hold.
- R2: The global enable resets to 0. It is set by `ei_i` and cleared by `di_i`, and when both arrive in the same cycle it is cleared. Sources 3 and above are presented only while it is 1.
- R3: Register address 0 is the mask. Bit j enables source 3+j: pins occupy bits 0..N_PIN-1, internal sources the next N_INT bits, group sources the next N_GRP bits. A masked source stays pending and is presented once its bit is set.
- R4: Register address 2, bit 0, is the group enable. While it is 0, no group source (the highest indices) is presented, whatever its mask bit holds.
- R5: Register address 1 holds two bits per pin, pin k at bits 2k+1:2k. The encodings are 00 high level, 01 low level, 10 rising edge and 11 falling edge.
- R6: An edge-mode pin event stays pending until acknowledged, and edges of the other polarity have no effect. A level-mode pin requests only while the pin is at its active level and never latches.
- R7: Source indices run in this order: fixed sources 0..2, pins from 3, internal sources from 3+N_PIN, group sources last. The lowest eligible index is presented.
- R8: Register address 3 is the vector base. `vec_o` equals base + 4 × `irq_idx_o`.
- R9: `ack_i` clears the pending bit of the source presented in that cycle. If a new event for the same source arrives in that cycle, the source stays pending.
- R10: After reset the mask, trigger modes, base, group enable and global enable are all 0, and no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable event (source 0) |
| badop_i | input | 1 | Illegal-opcode event (source 1) |
| trap_i | input | 1 | Software trap event (source 2) |
| pin_i | input | N_PIN | External interrupt pins |
| int_req_i | input | N_INT | Internal maskable event pulses |
| grp_req_i | input | N_GRP | Multiplexed group event pulses |
| ei_i | input | 1 | Enable command: sets the global enable |
| di_i | input | 1 | Disable command: clears the global enable |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 2 | Configuration register select |
| wr_data_i | input | DATA_W | Configuration write data |
| ack_i | input | 1 | Acknowledge of the presented request |
| irq_o | output | 1 | A request is presented |
| irq_idx_o | output | IDX_W | Index of the presented source |
| vec_o | output | ADDR_W | Vector address of the presented source |

## Verification
The bench drives a pin high and then releases it in level mode, and expects the request to vanish. A design that latched levels would keep requesting. It also drives edges of the wrong polarity, which a design with a swapped mode decode would turn into requests. Other cases are:
- Simultaneous enable and disable commands: a wrong ordering would leave interrupts enabled.
- A new event that coincides with an acknowledge of the same source: a wrong ordering drops it.
- A source masked while it is pending must reappear once enabled.
- Group sources must stay blocked while the group enable is 0 and their mask bits are 1.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_PIN  = 4,
  parameter int N_INT  = 4,
  parameter int N_GRP  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int N_FIX = 3,
  localparam int N_MSK = N_PIN + N_INT + N_GRP,
  localparam int N_SRC = N_FIX + N_MSK,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic              badop_i,
  input  logic              trap_i,
  input  logic [N_PIN-1:0]  pin_i,
  input  logic [N_INT-1:0]  int_req_i,
  input  logic [N_GRP-1:0]  grp_req_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  irq_idx_o,
  output logic [ADDR_W-1:0] vec_o
);
  localparam int PIN_LO = N_FIX;
  localparam int INT_LO = PIN_LO + N_PIN;
  localparam int GRP_LO = INT_LO + N_INT;

  logic [N_MSK-1:0]   mask_q;
  logic [2*N_PIN-1:0] mode_q;
  logic [ADDR_W-1:0]  base_q;
  logic               grp_en_q, gie_q;
  logic [N_SRC-1:0]   pend_q, pend_d, set_vec, clr_vec, lvl_vec, allow, elig;
  logic [N_PIN-1:0]   pin_q;

  always_comb begin
    set_vec = '0;
    lvl_vec = '0;
    set_vec[0] = nmi_i;
    set_vec[1] = badop_i;
    set_vec[2] = trap_i;
    for (int k = 0; k < N_PIN; k++) begin
      if (mode_q[2*k+1])
        set_vec[PIN_LO+k] = mode_q[2*k] ? (pin_q[k] & ~pin_i[k]) : (~pin_q[k] & pin_i[k]);
      else
        lvl_vec[PIN_LO+k] = mode_q[2*k] ? ~pin_i[k] : pin_i[k];
    end
    for (int k = 0; k < N_INT; k++) set_vec[INT_LO+k] = int_req_i[k];
    for (int k = 0; k < N_GRP; k++) set_vec[GRP_LO+k] = grp_req_i[k];
  end

  always_comb begin
    allow = '0;
    for (int i = 0; i < N_FIX; i++) allow[i] = 1'b1;
    for (int i = PIN_LO; i < GRP_LO; i++) allow[i] = mask_q[i-N_FIX] & gie_q;
    for (int i = GRP_LO; i < N_SRC; i++) allow[i] = mask_q[i-N_FIX] & gie_q & grp_en_q;
  end

  assign elig  = (pend_q | lvl_vec) & allow;
  assign irq_o = |elig;

  always_comb begin
    irq_idx_o = '0;
    for (int i = N_SRC-1; i >= 0; i--)
      if (elig[i]) irq_idx_o = IDX_W'(i);
  end

  assign vec_o = base_q + (ADDR_W'(irq_idx_o) << 2);

  always_comb begin
    clr_vec = '0;
    if (ack_i && irq_o) clr_vec[irq_idx_o] = 1'b1;
    pend_d = (pend_q & ~clr_vec) | set_vec;
    for (int k = 0; k < N_PIN; k++)
      if (!mode_q[2*k+1]) pend_d[PIN_LO+k] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      mode_q   <= '0;
      base_q   <= '0;
      grp_en_q <= 1'b0;
      gie_q    <= 1'b0;
      pend_q   <= '0;
      pin_q    <= '0;
    end else begin
      pend_q <= pend_d;
      pin_q  <= pin_i;
      if (di_i) gie_q <= 1'b0;
      else if (ei_i) gie_q <= 1'b1;
      if (wr_en_i) begin
        case (wr_addr_i)
          2'd0: mask_q   <= wr_data_i[N_MSK-1:0];
          2'd1: mode_q   <= wr_data_i[2*N_PIN-1:0];
          2'd2: grp_en_q <= wr_data_i[0];
          default: base_q <= wr_data_i[ADDR_W-1:0];
        endcase
      end
    end
  end

  assert_fixed_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[0] |-> (irq_o && irq_idx_o == '0));

  assert_gie_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_q && irq_o) |-> (irq_idx_o < IDX_W'(N_FIX)));

  assert_mask_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_idx_o >= IDX_W'(N_FIX)) |-> mask_q[irq_idx_o - IDX_W'(N_FIX)]);

  assert_grp_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_idx_o >= IDX_W'(GRP_LO)) |-> grp_en_q);

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> (!pend_q[$past(irq_idx_o)] || $past(set_vec[irq_idx_o])));

  for (genvar k = 0; k < N_PIN; k++) begin : g_lvl_chk
    assert_lvl_unlatched_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[2*k+1] |=> !pend_q[PIN_LO+k]);
  end
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi = 0, badop = 0, trap = 0, ei = 0, di = 0, wr_en = 0, ack = 0;
  logic [3:0] pins = 4'hA, intr = 0, grp = 0;
  logic [1:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic irq;
  logic [3:0] idx;
  logic [15:0] vec;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .badop_i(badop), .trap_i(trap),
    .pin_i(pins), .int_req_i(intr), .grp_req_i(grp), .ei_i(ei), .di_i(di),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ack_i(ack),
    .irq_o(irq), .irq_idx_o(idx), .vec_o(vec)
  );

  // row: {exp_idx, exp_irq, ack, grp, int, {trap,badop,nmi}, pins}
  localparam logic [20:0] TBL [0:20] = '{
    {4'd0, 1'b0, 1'b0, 4'h0, 4'h0, 3'b000, 4'hA},
    {4'd9, 1'b1, 1'b0, 4'h0, 4'h4, 3'b000, 4'hA},
    {4'd0, 1'b0, 1'b1, 4'h0, 4'h0, 3'b000, 4'hA},
    {4'd7, 1'b1, 1'b0, 4'h1, 4'h1, 3'b000, 4'hA},
    {4'd11,1'b1, 1'b1, 4'h0, 4'h0, 3'b000, 4'hA},
    {4'd0, 1'b0, 1'b1, 4'h0, 4'h0, 3'b000, 4'hA},
    {4'd3, 1'b1, 1'b0, 4'h0, 4'h0, 3'b000, 4'hB},
    {4'd0, 1'b0, 1'b0, 4'h0, 4'h0, 3'b000, 4'hA},
    {4'd4, 1'b1, 1'b0, 4'h0, 4'h0, 3'b000, 4'h8},
    {4'd0, 1'b0, 1'b1, 4'h0, 4'h0, 3'b000, 4'hA},
    {4'd5, 1'b1, 1'b0, 4'h0, 4'h0, 3'b000, 4'hE},
    {4'd5, 1'b1, 1'b0, 4'h0, 4'h0, 3'b000, 4'hE},
    {4'd5, 1'b1, 1'b0, 4'h0, 4'h0, 3'b000, 4'hA},
    {4'd5, 1'b1, 1'b0, 4'h0, 4'h0, 3'b000, 4'h2},
    {4'd6, 1'b1, 1'b1, 4'h0, 4'h0, 3'b000, 4'h2},
    {4'd0, 1'b0, 1'b1, 4'h0, 4'h0, 3'b000, 4'h2},
    {4'd2, 1'b1, 1'b0, 4'h0, 4'h0, 3'b100, 4'hA},
    {4'd0, 1'b1, 1'b0, 4'h0, 4'h0, 3'b011, 4'hA},
    {4'd1, 1'b1, 1'b1, 4'h0, 4'h0, 3'b000, 4'hA},
    {4'd2, 1'b1, 1'b1, 4'h0, 4'h0, 3'b000, 4'hA},
    {4'd0, 1'b0, 1'b1, 4'h0, 4'h0, 3'b000, 4'hA}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic expect_req(input string req, input bit e_irq, input int e_idx, input int base);
    chk(req, int'(irq), int'(e_irq));
    if (e_irq) begin
      chk(req, int'(idx), e_idx);
      chk({req, " vector R8"}, int'(vec), base + 4 * e_idx);
    end
  endtask

  task automatic step(input logic [3:0] p, input logic [2:0] src, input logic [3:0] in_r,
                      input logic [3:0] g_r, input logic a);
    pins = p; {trap, badop, nmi} = src; intr = in_r; grp = g_r; ack = a;
    @(posedge clk); @(negedge clk);
    {trap, badop, nmi} = 3'b000; intr = 0; grp = 0; ack = 0;
  endtask

  task automatic cfg(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cmd(input logic e, input logic d);
    ei = e; di = d;
    @(posedge clk); @(negedge clk);
    ei = 0; di = 0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset irq", int'(irq), 0);
    chk("R10 reset vec", int'(vec), 0);
    step(4'hA, 3'b000, 4'h1, 4'h0, 0);
    chk("R10 masked after reset", int'(irq), 0);
    step(4'hA, 3'b001, 4'h0, 4'h0, 0);
    expect_req("R1 nmi with gie off", 1, 0, 0);
    step(4'hA, 3'b000, 4'h0, 4'h0, 1);
    chk("R9 ack clears nmi", int'(irq), 0);
    cfg(2'd0, 16'h0FFF);
    cfg(2'd1, 16'h00E4);
    cfg(2'd3, 16'h1000);
    cfg(2'd2, 16'h0001);
    chk("R2 gie off blocks", int'(irq), 0);
    cmd(1, 0);
    expect_req("R3 pending kept while masked", 1, 7, 16'h1000);
    step(4'hA, 3'b000, 4'h0, 4'h0, 1);
    chk("R9 ack", int'(irq), 0);

    for (int r = 0; r < 21; r++) begin
      step(TBL[r][3:0], TBL[r][6:4], TBL[r][10:7], TBL[r][14:11], TBL[r][15]);
      pins = TBL[r][3:0];
      expect_req($sformatf("R7 R6 R5 row %0d", r), TBL[r][16], int'(TBL[r][20:17]), 16'h1000);
    end

    step(4'hA, 3'b000, 4'h2, 4'h0, 0);
    expect_req("R7 int1", 1, 8, 16'h1000);
    cmd(1, 1);
    chk("R2 disable wins", int'(irq), 0);
    cmd(1, 0);
    expect_req("R2 re-enabled", 1, 8, 16'h1000);
    step(4'hA, 3'b000, 4'h0, 4'h0, 1);

    cfg(2'd0, 16'h0FDF);
    step(4'hA, 3'b000, 4'h2, 4'h0, 0);
    chk("R3 masked int1", int'(irq), 0);
    cfg(2'd0, 16'h0FFF);
    expect_req("R3 unmasked int1", 1, 8, 16'h1000);
    step(4'hA, 3'b000, 4'h0, 4'h0, 1);

    cfg(2'd2, 16'h0000);
    step(4'hA, 3'b000, 4'h0, 4'h4, 0);
    chk("R4 group disabled", int'(irq), 0);
    cfg(2'd2, 16'h0001);
    expect_req("R4 group enabled", 1, 13, 16'h1000);
    cfg(2'd3, 16'h2000);
    expect_req("R8 new base", 1, 13, 16'h2000);
    step(4'hA, 3'b000, 4'h0, 4'h0, 1);
    chk("R9 ack group", int'(irq), 0);

    step(4'hA, 3'b000, 4'h1, 4'h0, 0);
    step(4'hA, 3'b000, 4'h1, 4'h0, 1);
    expect_req("R9 set beats ack", 1, 7, 16'h2000);
    step(4'hA, 3'b000, 4'h0, 4'h0, 1);
    chk("R9 cleared", int'(irq), 0);

    cfg(2'd1, 16'h00E6);
    step(4'hB, 3'b000, 4'h0, 4'h0, 0);
    expect_req("R5 pin0 rising", 1, 3, 16'h2000);
    step(4'hA, 3'b000, 4'h0, 4'h0, 0);
    expect_req("R6 edge held", 1, 3, 16'h2000);
    step(4'hA, 3'b000, 4'h0, 4'h0, 1);
    chk("R6 edge acked", int'(irq), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule